// File: doc/BRIEF.md
# Peripheral Request Line to Channel Mapper

This block sits between a set of peripheral request lines and the channels of a DMA engine. Software programs a table with one 8-bit entry per request line. Each entry holds an enable flag and a target channel number. The block brings each request line into the local clock domain. It detects every change of level on a line and routes the change to the channel that the line's entry names. For each channel it keeps the latched request level that the transfer logic consumes.

Two status signals are derived per channel from the direction of each routed change. The request-after-stop status is raised when a request arrives while the channel had no request latched, and any later change on that channel clears it. The end-of-receive event is a one-cycle pulse that fires when a request drops while the channel had one latched. Changes are handled one per clock cycle, and the lowest-numbered line is served first when several lines change together.

The table is reached through a simple register port. Entries 0 to 63 sit in a lower window and entries 64 and up sit in an upper window. A write that enables an entry with a channel number the engine does not have is refused and reported.

Top module: `dreq_mapper`

## Requirements
- R1: After reset every channel level, every request-after-stop status, every end-of-receive pulse and the error output are 0, and every table entry reads as 0x00.
- R2: Entry i is addressed at 0x100 + 4*i for i below 64 and at 0x1100 + 4*(i-64) for i from 64 to NUM_REQ-1. A read returns the stored 8-bit entry on reg_rdata in the cycle after reg_rd. An address outside both windows, or not a multiple of 4, reads 0x00, and a write to it changes no entry.
- R3: Entry bit 7 is the enable flag and bits 4:0 are the channel number, and bits 6:5 are stored and read back unchanged. A write with bit 7 set and a channel number of NUM_CH or more is not stored, and reg_err is high for exactly the one cycle after that write. Any other write to an entry is stored and leaves reg_err low.
- R4: A change on a request line whose entry has bit 7 clear changes no channel level, no status and no pulse.
- R5: A rise on an enabled line whose channel level is low sets that channel's level and sets its request-after-stop status.
- R6: Any other routed change on a channel clears that channel's request-after-stop status: a rise while the level is already high, or any fall.
- R7: A fall on an enabled line whose channel level is high clears the level and drives that channel's end-of-receive output high for exactly one cycle. A fall while the level is already low gives no pulse.
- R8: At most one change is routed per cycle. When several lines change together, the lowest-numbered line is routed first, and the next one follows in the next cycle.
- R9: A change that the bench applies between two rising edges shows on the channel outputs after the third rising edge that follows, because there are two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_REQ | Asynchronous peripheral request lines |
| reg_addr | input | 16 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Entry value to write |
| reg_rdata | output | 8 | Entry value read, valid in the cycle after reg_rd |
| reg_err | output | 1 | One-cycle pulse when a write named a channel that does not exist |
| ch_req | output | NUM_CH | Latched request level per channel |
| ras_stat | output | NUM_CH | Request-after-stop status per channel |
| eor_pulse | output | NUM_CH | One-cycle end-of-receive event per channel |

## Verification
The assertions assume that reset is held for at least one clock edge before any request or register activity. They also assume that every table entry is written only through the register port, so no stored enabled entry can name a channel outside the range. The bench holds reset for several cycles at the start, drives every input on the falling clock edge, and only changes request lines after their entries are programmed. Each request change is held for at least four cycles, unless the aim is to test simultaneous arrival.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;

    localparam int ENT_W      = 8;
    localparam int CH_FLD_W   = 5;
    localparam int IDX_W      = 7;
    localparam int LOW_CNT    = 64;
    localparam logic [15:0] LOW_BASE  = 16'h0100;
    localparam logic [15:0] HIGH_BASE = 16'h1100;

    typedef struct packed {
        logic                vld;
        logic [1:0]          rsv;
        logic [CH_FLD_W-1:0] ch;
    } map_ent_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_t;

    typedef struct packed {
        logic             fire;
        logic [IDX_W-1:0] idx;
        logic             lvl;
    } line_evt_t;

    typedef struct packed {
        logic                fire;
        logic [CH_FLD_W-1:0] ch;
        logic                lvl;
    } ch_evt_t;

    function automatic slot_t decode_slot(input logic [15:0] a, input int nreq);
        slot_t       s;
        logic [15:0] off;
        s   = '0;
        off = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= LOW_BASE && a < LOW_BASE + 16'(4 * LOW_CNT)) begin
                off = a - LOW_BASE;
                if (int'(off >> 2) < nreq) begin
                    s.hit = 1'b1;
                    s.idx = IDX_W'(off >> 2);
                end
            end else if (nreq > LOW_CNT && a >= HIGH_BASE &&
                         a < HIGH_BASE + 16'(4 * (nreq - LOW_CNT))) begin
                off   = a - HIGH_BASE;
                s.hit = 1'b1;
                s.idx = IDX_W'(LOW_CNT) + IDX_W'(off >> 2);
            end
        end
        return s;
    endfunction

    function automatic logic bad_channel(input map_ent_t e, input int nch);
        return e.vld && (int'({1'b0, e.ch}) >= nch);
    endfunction

endpackage

// File: rtl/dreq_sync_arb.sv
module dreq_sync_arb
    import dreq_map_pkg::*;
#(
    parameter int NUM_REQ     = 75,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_raw,
    input  logic               evt_taken,
    output line_evt_t          evt
);

    logic [NUM_REQ-1:0] stage_q [SYNC_STAGES];
    logic [NUM_REQ-1:0] level;
    logic [NUM_REQ-1:0] seen_q;
    logic [NUM_REQ-1:0] pend;
    logic [IDX_W-1:0]   pick;
    logic               found;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= req_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign level = stage_q[SYNC_STAGES-1];
    assign pend  = level ^ seen_q;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (!found && pend[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    assign evt.fire = found;
    assign evt.idx  = pick;
    assign evt.lvl  = level[pick];

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (evt.fire && evt_taken) begin
            seen_q[pick] <= evt.lvl;
        end
    end

endmodule

// File: rtl/dreq_map_table.sv
module dreq_map_table
    import dreq_map_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [ENT_W-1:0] reg_wdata,
    output logic [ENT_W-1:0] reg_rdata,
    output logic             reg_err,
    input  logic [IDX_W-1:0] lk_idx,
    output map_ent_t         lk_ent
);

    map_ent_t tbl [NUM_REQ];
    slot_t    slot;
    map_ent_t wr_ent;
    logic     refuse;

    assign slot   = decode_slot(reg_addr, NUM_REQ);
    assign wr_ent = map_ent_t'(reg_wdata);
    assign refuse = bad_channel(wr_ent, NUM_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REQ; i++) tbl[i] <= '0;
            reg_err <= 1'b0;
        end else begin
            reg_err <= reg_wr && slot.hit && refuse;
            if (reg_wr && slot.hit && !refuse) begin
                tbl[slot.idx] <= wr_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= slot.hit ? ENT_W'(tbl[slot.idx]) : '0;
        end
    end

    always_comb begin
        lk_ent = '0;
        if (int'(lk_idx) < NUM_REQ) lk_ent = tbl[lk_idx];
    end

endmodule

// File: rtl/dreq_chan_state.sv
module dreq_chan_state
    import dreq_map_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_evt_t           cev,
    output logic [NUM_CH-1:0] ch_req,
    output logic [NUM_CH-1:0] ras_stat,
    output logic [NUM_CH-1:0] eor_pulse
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = cev.fire && (cev.ch == CH_FLD_W'(c));

            always_ff @(posedge clk) begin
                if (rst) begin
                    ch_req[c]    <= 1'b0;
                    ras_stat[c]  <= 1'b0;
                    eor_pulse[c] <= 1'b0;
                end else begin
                    eor_pulse[c] <= hit && !cev.lvl && ch_req[c];
                    if (hit) begin
                        ras_stat[c] <= cev.lvl && !ch_req[c];
                        ch_req[c]   <= cev.lvl;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dreq_mapper.sv
module dreq_mapper
    import dreq_map_pkg::*;
#(
    parameter int NUM_REQ     = 75,
    parameter int NUM_CH      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic [15:0]        reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               reg_err,
    output logic [NUM_CH-1:0]  ch_req,
    output logic [NUM_CH-1:0]  ras_stat,
    output logic [NUM_CH-1:0]  eor_pulse
);

    line_evt_t evt;
    map_ent_t  ent;
    ch_evt_t   cev;

    dreq_sync_arb #(
        .NUM_REQ     (NUM_REQ),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req_raw   (req_in),
        .evt_taken (1'b1),
        .evt       (evt)
    );

    dreq_map_table #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .lk_idx    (evt.idx),
        .lk_ent    (ent)
    );

    assign cev.fire = evt.fire && ent.vld;
    assign cev.ch   = ent.ch;
    assign cev.lvl  = evt.lvl;

    dreq_chan_state #(
        .NUM_CH (NUM_CH)
    ) u_chs (
        .clk       (clk),
        .rst       (rst),
        .cev       (cev),
        .ch_req    (ch_req),
        .ras_stat  (ras_stat),
        .eor_pulse (eor_pulse)
    );

endmodule

// File: rtl/dreq_mapper_chk.sv
module dreq_mapper_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_err,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ras_stat,
    input logic [NUM_CH-1:0] eor_pulse
);

    // R3: an error pulse only follows a write
    a_r3_err_after_write: assert property (@(posedge clk) disable iff (rst)
        reg_err |-> $past(reg_wr));

    // R3: the error lasts one cycle unless another write follows
    a_r3_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (reg_err && !$past(reg_wr, 1)) |-> 1'b0);

    // R7: at most one end-of-receive event at a time
    a_r7_eor_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eor_pulse));

    // R7: an event only where the level just fell
    a_r7_eor_on_fall: assert property (@(posedge clk) disable iff (rst)
        ((eor_pulse & ch_req) == '0) && ((eor_pulse & ~$past(ch_req)) == '0));

    // R5: the status only rises together with the channel level
    a_r5_ras_with_rise: assert property (@(posedge clk) disable iff (rst)
        ((ras_stat & ~$past(ras_stat)) & ~(ch_req & ~$past(ch_req))) == '0);

    // R6: the status never survives a low channel level
    a_r6_ras_needs_level: assert property (@(posedge clk) disable iff (rst)
        (ras_stat & ~ch_req) == '0);

    // R8: one routed change per cycle
    a_r8_one_change: assert property (@(posedge clk) disable iff (rst)
        $countones(ch_req ^ $past(ch_req)) <= 1);

endmodule

bind dreq_mapper dreq_mapper_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_err   (reg_err),
    .ch_req    (ch_req),
    .ras_stat  (ras_stat),
    .eor_pulse (eor_pulse)
);

// File: tb/dreq_mapper_test.sv
module dreq_mapper_test;

    localparam int NR = 75;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] req = '0;
    logic [15:0]   addr = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          err;
    logic [NC-1:0] ch_req, ras, eor;

    int total = 0;
    int bad = 0;
    int eor_cnt [NC];

    dreq_mapper #(.NUM_REQ(NR), .NUM_CH(NC)) uut (
        .clk(clk), .rst(rst), .req_in(req), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .reg_err(err),
        .ch_req(ch_req), .ras_stat(ras), .eor_pulse(eor)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NC; c++) if (eor[c]) eor_cnt[c]++;
        end
    end

    typedef struct packed {
        logic [6:0] idx;
        logic       lvl;
        logic [3:0] ch;
        logic       e_req;
        logic       e_ras;
        logic [3:0] e_eor;
    } vec_t;

    // line, new level, channel watched, expected level, status, total events
    localparam vec_t VECS [10] = '{
        '{7'd0,  1'b1, 4'd0,  1'b1, 1'b1, 4'd0},  // R5
        '{7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 4'd1},  // R7
        '{7'd10, 1'b1, 4'd3,  1'b1, 1'b1, 4'd0},  // R5
        '{7'd11, 1'b1, 4'd3,  1'b1, 1'b0, 4'd0},  // R6 rise while high
        '{7'd11, 1'b0, 4'd3,  1'b0, 1'b0, 4'd1},  // R7
        '{7'd10, 1'b0, 4'd3,  1'b0, 1'b0, 4'd1},  // R7 fall while low
        '{7'd70, 1'b1, 4'd15, 1'b1, 1'b1, 4'd0},  // R5 upper window line
        '{7'd70, 1'b0, 4'd15, 1'b0, 1'b0, 4'd1},  // R7
        '{7'd40, 1'b1, 4'd2,  1'b0, 1'b0, 4'd0},  // R4 disabled entry
        '{7'd40, 1'b0, 4'd2,  1'b0, 1'b0, 4'd0}   // R4
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d, output logic e);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        step(1);
        wr    = 1'b0;
        step(1);
        e     = err;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [7:0] d);
        addr = a;
        rd   = 1'b1;
        step(1);
        rd   = 1'b0;
        d    = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       e;

        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        check("R1 ch_req", int'(ch_req), 0);
        check("R1 ras", int'(ras), 0);
        check("R1 eor", int'(eor), 0);
        check("R1 err", int'(err), 0);
        reg_read(16'h0100, d); check("R1 entry0", d, 0);
        reg_read(16'h1128, d); check("R1 entry74", d, 0);

        // program the table
        reg_write(16'h0100, 8'h80, e);
        reg_write(16'h0128, 8'h83, e);
        reg_write(16'h012C, 8'h83, e);
        reg_write(16'h1118, 8'h8F, e);
        reg_write(16'h01A0, 8'h02, e);
        reg_write(16'h0150, 8'h85, e);
        reg_write(16'h0178, 8'h86, e);

        // R2 windows and readback
        reg_read(16'h1118, d); check("R2 entry70", d, 8'h8F);
        reg_read(16'h01A0, d); check("R2 entry40", d, 8'h02);
        reg_write(16'h1128, 8'hE4, e);
        check("R3 good write no err", e, 0);
        reg_read(16'h1128, d); check("R3 rsv bits kept entry74", d, 8'hE4);
        reg_read(16'h0200, d); check("R2 gap reads zero", d, 0);
        reg_read(16'h0102, d); check("R2 misaligned reads zero", d, 0);
        reg_write(16'h2000, 8'h81, e);
        reg_read(16'h2000, d); check("R2 outside reads zero", d, 0);
        reg_read(16'h0100, d); check("R2 outside write ignored", d, 8'h80);

        // R3 refused writes
        addr = 16'h0104; wdata = 8'h90; wr = 1'b1;
        step(1);
        wr = 1'b0;
        check("R3 err pulse", int'(err), 1);
        step(1);
        check("R3 err one cycle", int'(err), 0);
        reg_read(16'h0104, d); check("R3 refused not stored", d, 0);
        reg_write(16'h0104, 8'h10, e);
        reg_read(16'h0104, d); check("R3 disabled high ch stored", d, 8'h10);
        reg_write(16'h0104, 8'h8F, e);
        reg_read(16'h0104, d); check("R3 top channel stored", d, 8'h8F);
        addr = 16'h0104; wdata = 8'h9F; wr = 1'b1;
        step(1);
        wr = 1'b0;
        check("R3 err again", int'(err), 1);
        step(1);
        reg_read(16'h0104, d); check("R3 old entry kept", d, 8'h8F);

        // table of request changes
        foreach (VECS[k]) begin
            req[VECS[k].idx] = VECS[k].lvl;
            step(4);
            check($sformatf("R5/R6/R7 vec%0d level", k), int'(ch_req[VECS[k].ch]), int'(VECS[k].e_req));
            check($sformatf("R5/R6 vec%0d status", k), int'(ras[VECS[k].ch]), int'(VECS[k].e_ras));
            check($sformatf("R7 vec%0d events", k), eor_cnt[VECS[k].ch], int'(VECS[k].e_eor));
        end
        check("R4 no channel moved", int'(ch_req), 0);

        // R9 latency, line 74 mapped to channel 4
        req[74] = 1'b1;
        step(2);
        check("R9 not yet after two edges", int'(ch_req[4]), 0);
        step(1);
        check("R9 level after third edge", int'(ch_req[4]), 1);
        check("R9 status after third edge", int'(ras[4]), 1);

        // R7 pulse width
        req[74] = 1'b0;
        step(3);
        check("R7 pulse high", int'(eor[4]), 1);
        step(1);
        check("R7 pulse one cycle", int'(eor[4]), 0);

        // R8 simultaneous lines 20 and 30 on channels 5 and 6
        req[20] = 1'b1;
        req[30] = 1'b1;
        step(3);
        check("R8 lower line first", int'(ch_req[5]), 1);
        check("R8 higher line waits", int'(ch_req[6]), 0);
        step(1);
        check("R8 higher line next", int'(ch_req[6]), 1);
        check("R8 both status", int'(ras[6:5]), 3);

        // R6 fall clears status
        req[20] = 1'b0;
        step(4);
        check("R6 fall clears status", int'(ras[5]), 0);
        check("R7 fall event counted", eor_cnt[5], 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule